// File: doc/BRIEF.md
# Data/Command Symbol Decoder Latch

This block sits behind a symbol aligner on a serial link receiver. Each cycle in which the load strobe is high, it takes one aligned symbol word and sorts it into one of three classes: a data value, a command value, or a code violation. It holds data and command results in two separate output registers. A transfer of one class never touches the register of the other class. Each transfer gives a one-cycle strobe that names the register it updated.

A two-bit mode input sets the split between data and command widths. Mode 0 gives 8 data bits or a 4-bit command from a 10-bit symbol. Mode 1 gives 9 data bits or a 3-bit command from an 11-bit symbol. Mode 2 gives 10 data bits or a 2-bit command from a 12-bit symbol. The symbol occupies the low bits of the input word. The code table is built from parameters: the two-bit class tag values and the width range.

The link idle pattern is an ordinary command code. For that reason the command strobe keeps firing while no data flows.

Top module: `sdl_decoder_latch`

## Requirements
- R1: Every cycle with load high produces, on the next cycle, exactly one of the data strobe and the command strobe. A cycle with load low produces neither strobe on the next cycle.
- R2: In mode m, the symbol width is sw = 10+m and the data width is dw = 8+m. A symbol whose tag bits [sw-1:dw] equal 2'b10 is a data symbol. On the next cycle data_o holds bits [dw-1:0] zero-extended, and the data strobe pulses.
- R3: A data transfer leaves cmd_o unchanged.
- R4: In mode m, the command width is cw = 4-m. A symbol whose tag bits [sw-1:dw] equal 2'b01 and whose bits [dw-1:cw] are all zero is a command symbol. On the next cycle cmd_o holds bits [cw-1:0] zero-extended, and the command strobe pulses.
- R5: A command transfer, and a violation, leave data_o unchanged.
- R6: The idle symbol, a command whose cw low bits are all ones, gives one command strobe per load when sent back to back.
- R7: Any other symbol is a violation. On the next cycle it pulses the command strobe, raises viol_o, and sets cmd_o to zero. viol_o is low in every other cycle.
- R8: Mode 3 is reserved. Every symbol loaded in mode 3 is a violation.
- R9: Input bits at or above the symbol width of the current mode have no effect.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Width mode (0, 1 and 2 are valid; 3 is reserved) |
| load_i | input | 1 | Symbol valid this cycle |
| sym_i | input | 12 | Aligned symbol, right-justified |
| data_o | output | 10 | Latest data value, zero-extended |
| cmd_o | output | 4 | Latest command value, zero-extended |
| data_stb_o | output | 1 | One-cycle pulse on a data transfer |
| cmd_stb_o | output | 1 | One-cycle pulse on a command or violation transfer |
| viol_o | output | 1 | One-cycle pulse on a violation transfer |

## Verification
All results are due exactly one clock after the edge that samples load_i: the outputs, both strobes and viol_o. No result has a longer path. The bench drives each symbol on a falling edge and lets one rising edge pass. It then compares every output on the following falling edge against a model that tracks the last data and command values. The bench keeps load high across whole sweeps, so back-to-back transfers are checked cycle by cycle. Each mode is swept over all 4096 input words, and an idle cycle is checked for the absence of strobes.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_VIOL = 2'd2
  } sdl_kind_e;
endpackage

// File: rtl/sdl_classify.sv
module sdl_classify
  import sdl_pkg::*;
#(
  parameter int             DW_MIN   = 8,
  parameter int             N_MODES  = 3,
  parameter int             CW_MAX   = 4,
  parameter int             TAG_W    = 2,
  parameter logic [TAG_W-1:0] DATA_TAG = 2'b10,
  parameter logic [TAG_W-1:0] CMD_TAG  = 2'b01,
  localparam int            DW_MAX   = DW_MIN + N_MODES - 1,
  localparam int            SW_MAX   = DW_MAX + TAG_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SW_MAX-1:0] sym_i,
  output sdl_kind_e         kind_o,
  output logic [DW_MAX-1:0] data_o,
  output logic [CW_MAX-1:0] cmd_o
);
  localparam int SLOTS = 1 << MODE_W;

  logic [SLOTS-1:0]             data_hit;
  logic [SLOTS-1:0]             cmd_hit;
  logic [SLOTS-1:0][DW_MAX-1:0] data_m;
  logic [SLOTS-1:0][CW_MAX-1:0] cmd_m;

  for (genvar m = 0; m < SLOTS; m++) begin : g_mode
    if (m < N_MODES) begin : g_live
      localparam int DW = DW_MIN + m;
      localparam int CW = CW_MAX - m;
      localparam int SW = DW + TAG_W;

      logic [TAG_W-1:0] tag;
      logic             fill_zero;
      logic             is_data;
      logic             is_cmd;

      assign tag       = sym_i[SW-1:DW];
      assign fill_zero = (sym_i[DW-1:CW] == '0);

      always_comb begin
        is_data = 1'b0;
        is_cmd  = 1'b0;
        case (tag)
          DATA_TAG: is_data = 1'b1;
          CMD_TAG:  is_cmd  = fill_zero;
          default:  ;
        endcase
      end

      assign data_hit[m] = is_data;
      assign cmd_hit[m]  = is_cmd;
      assign data_m[m]   = DW_MAX'(sym_i[DW-1:0]);
      assign cmd_m[m]    = CW_MAX'(sym_i[CW-1:0]);
    end else begin : g_rsvd
      assign data_hit[m] = 1'b0;
      assign cmd_hit[m]  = 1'b0;
      assign data_m[m]   = '0;
      assign cmd_m[m]    = '0;
    end
  end

  always_comb begin
    kind_o = KIND_VIOL;
    data_o = data_m[mode_i];
    cmd_o  = '0;
    if (data_hit[mode_i]) begin
      kind_o = KIND_DATA;
    end else if (cmd_hit[mode_i]) begin
      kind_o = KIND_CMD;
      cmd_o  = cmd_m[mode_i];
    end
  end
endmodule

// File: rtl/sdl_out_bank.sv
module sdl_out_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // R3/R5: a bank moves only on its own load
  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/sdl_decoder_latch.sv
module sdl_decoder_latch
  import sdl_pkg::*;
#(
  parameter int               DW_MIN   = 8,
  parameter int               N_MODES  = 3,
  parameter int               CW_MAX   = 4,
  parameter int               TAG_W    = 2,
  parameter logic [TAG_W-1:0] DATA_TAG = 2'b10,
  parameter logic [TAG_W-1:0] CMD_TAG  = 2'b01,
  localparam int              DW_MAX   = DW_MIN + N_MODES - 1,
  localparam int              SW_MAX   = DW_MAX + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic [SW_MAX-1:0] sym_i,
  output logic [DW_MAX-1:0] data_o,
  output logic [CW_MAX-1:0] cmd_o,
  output logic              data_stb_o,
  output logic              cmd_stb_o,
  output logic              viol_o
);
  sdl_kind_e         kind;
  logic [DW_MAX-1:0] dec_data;
  logic [CW_MAX-1:0] dec_cmd;
  logic              data_load;
  logic              cmd_load;

  sdl_classify #(
    .DW_MIN  (DW_MIN),
    .N_MODES (N_MODES),
    .CW_MAX  (CW_MAX),
    .TAG_W   (TAG_W),
    .DATA_TAG(DATA_TAG),
    .CMD_TAG (CMD_TAG)
  ) u_classify (
    .mode_i(mode_i),
    .sym_i (sym_i),
    .kind_o(kind),
    .data_o(dec_data),
    .cmd_o (dec_cmd)
  );

  assign data_load = load_i && (kind == KIND_DATA);
  // violations take the command path with a zero value
  assign cmd_load  = load_i && (kind != KIND_DATA);

  sdl_out_bank #(.W(DW_MAX)) u_data_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(data_load),
    .d_i   (dec_data),
    .q_o   (data_o)
  );

  sdl_out_bank #(.W(CW_MAX)) u_cmd_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cmd_load),
    .d_i   (dec_cmd),
    .q_o   (cmd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_stb_o <= 1'b0;
      cmd_stb_o  <= 1'b0;
      viol_o     <= 1'b0;
    end else begin
      data_stb_o <= data_load;
      cmd_stb_o  <= cmd_load;
      viol_o     <= load_i && (kind == KIND_VIOL);
    end
  end

  p_one_stb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ($countones({data_stb_o, cmd_stb_o}) == 1));

  p_idle_stb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !data_stb_o && !cmd_stb_o && !viol_o);

  p_cmd_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_stb_o |-> $stable(cmd_o));

  p_data_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> $stable(data_o));

  p_viol_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> cmd_stb_o && (cmd_o == '0));

  p_rsvd_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (mode_i >= 2'(N_MODES))) |=> viol_o);
endmodule

// File: tb/sdl_decoder_latch_bench.sv
`timescale 1ns/1ps
module sdl_decoder_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        load = 1'b0;
  logic [11:0] sym = '0;
  logic [9:0]  data_o;
  logic [3:0]  cmd_o;
  logic        data_stb, cmd_stb, viol;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [9:0] exp_data = '0;
  logic [3:0] exp_cmd  = '0;

  always #4 clk = ~clk;

  sdl_decoder_latch u_sdl_decoder_latch (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .load_i    (load),
    .sym_i     (sym),
    .data_o    (data_o),
    .cmd_o     (cmd_o),
    .data_stb_o(data_stb),
    .cmd_stb_o (cmd_stb),
    .viol_o    (viol)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s mode=%0d sym=%03h actual=%0h expected=%0h",
               req, mode, sym, act, exp_v);
    end
  endtask

  // kind: 0 data, 1 command, 2 violation
  task automatic model(input int m, input int s, output int kind, output int val);
    int dw, cw, tag;
    kind = 2;
    val  = 0;
    if (m <= 2) begin
      dw  = 8 + m;
      cw  = 4 - m;
      tag = (s >> dw) & 3;
      if (tag == 2) begin
        kind = 0;
        val  = s & ((1 << dw) - 1);
      end else if (tag == 1 && ((s >> cw) & ((1 << (dw - cw)) - 1)) == 0) begin
        kind = 1;
        val  = s & ((1 << cw) - 1);
      end
    end
  endtask

  // drive at a falling edge, check one rising edge later at the next falling edge
  task automatic apply(input int m, input int s, input string tag);
    int kind, val;
    mode = 2'(m);
    sym  = 12'(s);
    load = 1'b1;
    model(m, s, kind, val);
    @(negedge clk);
    if (kind == 0) exp_data = 10'(val);
    else           exp_cmd  = 4'(val);
    chk({tag, " R1 strobe count"}, int'(data_stb) + int'(cmd_stb), 1);
    chk(kind == 0 ? {tag, " R2 data_o"} : {tag, " R5 data_o kept"}, int'(data_o), int'(exp_data));
    chk(kind == 1 ? {tag, " R4 cmd_o"} : (kind == 0 ? {tag, " R3 cmd_o kept"} : {tag, " R7 cmd_o zero"}),
        int'(cmd_o), int'(exp_cmd));
    chk({tag, " R7 viol_o"}, int'(viol), int'(kind == 2));
    chk({tag, " R1 data strobe"}, int'(data_stb), int'(kind == 0));
  endtask

  initial begin
    #3;
    chk("R10 reset data_o", int'(data_o), 0);
    chk("R10 reset cmd_o", int'(cmd_o), 0);
    chk("R10 reset strobes", int'({data_stb, cmd_stb, viol}), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no load no strobe", int'({data_stb, cmd_stb, viol}), 0);

    // R6: back-to-back idle symbols in mode 0
    for (int i = 0; i < 6; i++) apply(0, 12'h10F, "R6 idle");

    // exhaustive sweeps; words above symbol width exercise R9, mode 3 exercises R8
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4096; s++) begin
        if (m == 3) apply(m, s, "R8 reserved");
        else if ((s >> (10 + m)) != 0) apply(m, s, "R9 high bits");
        else apply(m, s, "sweep");
      end
    end

    // R1: idle cycle after traffic keeps outputs and strobes quiet
    load = 1'b0;
    @(negedge clk);
    chk("R1 idle strobes", int'({data_stb, cmd_stb, viol}), 0);
    chk("R1 idle data_o held", int'(data_o), int'(exp_data));
    chk("R1 idle cmd_o held", int'(cmd_o), int'(exp_cmd));

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule